// File: doc/BRIEF.md
# Thread Migration Context Slot Manager

This block is the per-core controller of a shared memory scheme in which each address may be touched only at its home core. The home core is a fixed group of address bits. When a thread's access names this core, the access goes straight to the local cache port. When it names another core, the thread is halted before the access has any effect. Its full architectural context is then streamed out as network flits to the home core, and on arrival the thread re-executes the faulting access.

Each core has two context slots. The native slot holds only the thread that began on this core. The guest slot holds one visiting thread. An arriving context is steered by the native-core ID in its header. A foreign arrival that finds the guest slot occupied first forces the occupant home to its own native core. A native-bound arrival never needs to evict anything, so migration cannot deadlock. Context registers are written and read by the pipeline through a word port. The pipeline, cache and network are reduced to ready/valid handshakes.

Top module: `mig_slot_ctrl`

## Requirements
- R1: The home core is `acc_addr[HOME_LSB +: log2(NCORES)]`. An accepted access whose home equals `core_id` raises `cache_valid` on the next cycle, carrying the access's address, write flag and slot. The request is held unchanged until `cache_ready` is high.
- R2: An accepted access whose home differs from `core_id` produces no cache request. The issuing slot's `slot_run` bit is low on the next cycle.
- R3: A migration sends a header flit followed by five data flits. Header layout: bit 255 = 1, bits [1:0] = destination core, bits [3:2] = the thread's native core, bit 4 = 1 for an eviction and 0 for a core miss. Data flit k bits [32j+31:32j] hold context word 8k+j. Words 0–31 are the general registers, word 32 the instruction pointer and word 33 the status word. Positions past word 33 are zero.
- R4: While `tx_valid` is high and `tx_ready` is low, the flit is held. `tx_done` is high for exactly one cycle, the cycle after the last flit's handshake.
- R5: After its packet is sent, the migrated slot is empty: its `slot_run` bit stays low.
- R6: An arriving context whose header native field equals `core_id` is installed in slot 0 (native); any other goes to slot 1 (guest). After the last data flit, the slot's `slot_run` bit is high and the read port returns the received words.
- R7: If a foreign context arrives while the guest slot is occupied, `rx_ready` drops after the header. The guest is then sent to its own native core with the eviction bit set, and the incoming data is accepted afterwards.
- R8: When a native-slot core miss and a guest eviction are both pending, the native migration is sent first.
- R9: A register write to a slot whose `slot_run` bit is low is ignored.
- R10: After reset, `slot_run` = 2'b01, all context words read zero, and `tx_valid` and `cache_valid` are low with `rx_ready` high.
- R11: An access whose slot is not running is not accepted (`acc_ready` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_id | input | 2 | This core's index |
| acc_valid | input | 1 | Memory access request |
| acc_slot | input | 1 | Issuing slot (0 native, 1 guest) |
| acc_write | input | 1 | Access is a store |
| acc_addr | input | 32 | Access address |
| acc_ready | output | 1 | Access accepted this cycle |
| cache_valid | output | 1 | Local cache request |
| cache_write | output | 1 | Cache request is a store |
| cache_slot | output | 1 | Slot owning the cache request |
| cache_addr | output | 32 | Cache request address |
| cache_ready | input | 1 | Cache takes the request |
| slot_run | output | 2 | Per-slot may-execute flags |
| reg_we | input | 1 | Context word write |
| reg_slot | input | 1 | Slot for write |
| reg_idx | input | 6 | Word index for write |
| reg_wdata | input | 32 | Write data |
| rd_slot | input | 1 | Slot for read |
| rd_idx | input | 6 | Word index for read |
| rd_data | output | 32 | Read data, one cycle later |
| tx_valid | output | 1 | Outgoing flit valid |
| tx_flit | output | 256 | Outgoing flit |
| tx_ready | input | 1 | Network takes the flit |
| tx_done | output | 1 | Pulse after a packet's last flit |
| rx_valid | input | 1 | Incoming flit valid |
| rx_flit | input | 256 | Incoming flit |
| rx_ready | output | 1 | Incoming flit accepted |

## Verification
Two functions can land on the single outgoing serializer at the same moment: a native-slot core miss and the eviction of the guest that a foreign arrival demands. The bench sends a foreign header while the guest slot is full. On the very next cycle it issues a native-slot access to a remote home, so both slots are marked for departure when the serializer comes free. It judges the result by the order of the two headers on the wire: destination and native fields of the native thread with the eviction bit clear come first, then the guest's header with the bit set. Each is followed by that slot's exact words. Only after both does the arrival's data install.

// File: rtl/mig_pkg.sv
package mig_pkg;
  localparam int SLOTS       = 2;
  localparam int NATIVE_SLOT = 0;
  localparam int GUEST_SLOT  = 1;

  typedef enum logic [1:0] {
    RX_HDR  = 2'd0,
    RX_WAIT = 2'd1,
    RX_DATA = 2'd2
  } rx_state_e;
endpackage

// File: rtl/mig_access.sv
module mig_access #(
  parameter int CW       = 2,
  parameter int AW       = 32,
  parameter int HOME_LSB = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] core_id,
  input  logic          acc_valid,
  input  logic          acc_slot,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  output logic          acc_ready,
  input  logic [1:0]    slot_run,
  input  logic          cache_ready,
  output logic          cache_valid,
  output logic          cache_write,
  output logic          cache_slot,
  output logic [AW-1:0] cache_addr,
  output logic          miss_valid,
  output logic          miss_slot,
  output logic [CW-1:0] miss_home
);
  logic [CW-1:0] home;
  logic          local_hit;
  logic          take;

  assign home      = acc_addr[HOME_LSB +: CW];
  assign local_hit = (home == core_id);
  assign acc_ready = slot_run[acc_slot] && (!cache_valid || cache_ready);
  assign take      = acc_valid && acc_ready;

  assign miss_valid = take && !local_hit;
  assign miss_slot  = acc_slot;
  assign miss_home  = home;

  always_ff @(posedge clk) begin
    if (rst) begin
      cache_valid <= 1'b0;
      cache_write <= 1'b0;
      cache_slot  <= 1'b0;
      cache_addr  <= '0;
    end else if (take && local_hit) begin
      cache_valid <= 1'b1;
      cache_write <= acc_write;
      cache_slot  <= acc_slot;
      cache_addr  <= acc_addr;
    end else if (cache_ready) begin
      cache_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mig_tx.sv
module mig_tx #(
  parameter int CW         = 2,
  parameter int FLIT_W     = 256,
  parameter int CTX_BITS   = 1088,
  parameter int DATA_FLITS = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [CW-1:0]       hdr_dest,
  input  logic [CW-1:0]       hdr_native,
  input  logic                hdr_evict,
  input  logic [CTX_BITS-1:0] ctx,
  output logic                tx_valid,
  output logic [FLIT_W-1:0]   tx_flit,
  input  logic                tx_ready,
  output logic                busy,
  output logic                done
);
  localparam int FLITS = DATA_FLITS + 1;
  localparam int IDXW  = (FLITS > 1) ? $clog2(FLITS) : 1;
  localparam int PADW  = DATA_FLITS * FLIT_W;

  logic [PADW-1:0] padded;
  logic [IDXW-1:0] idx_q;
  logic [FLIT_W-1:0] hdr;

  assign padded = {{(PADW-CTX_BITS){1'b0}}, ctx};

  always_comb begin
    hdr = '0;
    hdr[FLIT_W-1]      = 1'b1;
    hdr[CW-1:0]        = hdr_dest;
    hdr[2*CW-1:CW]     = hdr_native;
    hdr[2*CW]          = hdr_evict;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_flit  <= '0;
      idx_q    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        tx_valid <= 1'b1;
        tx_flit  <= hdr;
        idx_q    <= '0;
        busy     <= 1'b1;
      end else if (tx_valid && tx_ready) begin
        if (int'(idx_q) == FLITS - 1) begin
          tx_valid <= 1'b0;
          busy     <= 1'b0;
          done     <= 1'b1;
        end else begin
          tx_flit <= padded[int'(idx_q)*FLIT_W +: FLIT_W];
          idx_q   <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mig_rx.sv
module mig_rx
  import mig_pkg::*;
#(
  parameter int CW         = 2,
  parameter int FLIT_W     = 256,
  parameter int DATA_FLITS = 5,
  parameter int DIDXW      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    core_id,
  input  logic             rx_valid,
  input  logic [FLIT_W-1:0] rx_flit,
  output logic             rx_ready,
  input  logic [1:0]       slot_occ,
  output logic             evict_req,
  output logic             wr_en,
  output logic             wr_slot,
  output logic [DIDXW-1:0] wr_fidx,
  output logic [FLIT_W-1:0] wr_flit,
  output logic             install,
  output logic             inst_slot,
  output logic [CW-1:0]    inst_native
);
  rx_state_e        state_q;
  logic             tgt_q;
  logic [CW-1:0]    nat_q;
  logic [DIDXW-1:0] cnt_q;
  logic [CW-1:0]    hdr_nat;

  assign hdr_nat = rx_flit[2*CW-1:CW];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_HDR;
      tgt_q   <= 1'b0;
      nat_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        RX_HDR: if (rx_valid) begin
          nat_q   <= hdr_nat;
          tgt_q   <= (hdr_nat == core_id) ? 1'b0 : 1'b1;
          state_q <= RX_WAIT;
        end
        RX_WAIT: if (!slot_occ[tgt_q]) begin
          cnt_q   <= '0;
          state_q <= RX_DATA;
        end
        RX_DATA: if (rx_valid) begin
          if (int'(cnt_q) == DATA_FLITS - 1) state_q <= RX_HDR;
          else                               cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= RX_HDR;
      endcase
    end
  end

  assign rx_ready    = (state_q != RX_WAIT);
  assign evict_req   = (state_q == RX_WAIT) && tgt_q && slot_occ[GUEST_SLOT];
  assign wr_en       = (state_q == RX_DATA) && rx_valid;
  assign wr_slot     = tgt_q;
  assign wr_fidx     = cnt_q;
  assign wr_flit     = rx_flit;
  assign install     = wr_en && (int'(cnt_q) == DATA_FLITS - 1);
  assign inst_slot   = tgt_q;
  assign inst_native = nat_q;
endmodule

// File: rtl/mig_slot_ctrl.sv
module mig_slot_ctrl
  import mig_pkg::*;
#(
  parameter int NCORES   = 4,
  parameter int AW       = 32,
  parameter int HOME_LSB = 12,
  parameter int XLEN     = 32,
  parameter int NREGS    = 32,
  parameter int FLIT_W   = 256,
  localparam int CW         = $clog2(NCORES),
  localparam int WORDS      = NREGS + 2,
  localparam int IW         = $clog2(WORDS),
  localparam int CTX_BITS   = WORDS * XLEN,
  localparam int DATA_FLITS = (CTX_BITS + FLIT_W - 1) / FLIT_W,
  localparam int WPF        = FLIT_W / XLEN,
  localparam int DIDXW      = (DATA_FLITS > 1) ? $clog2(DATA_FLITS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     core_id,
  input  logic              acc_valid,
  input  logic              acc_slot,
  input  logic              acc_write,
  input  logic [AW-1:0]     acc_addr,
  output logic              acc_ready,
  output logic              cache_valid,
  output logic              cache_write,
  output logic              cache_slot,
  output logic [AW-1:0]     cache_addr,
  input  logic              cache_ready,
  output logic [1:0]        slot_run,
  input  logic              reg_we,
  input  logic              reg_slot,
  input  logic [IW-1:0]     reg_idx,
  input  logic [XLEN-1:0]   reg_wdata,
  input  logic              rd_slot,
  input  logic [IW-1:0]     rd_idx,
  output logic [XLEN-1:0]   rd_data,
  output logic              tx_valid,
  output logic [FLIT_W-1:0] tx_flit,
  input  logic              tx_ready,
  output logic              tx_done,
  input  logic              rx_valid,
  input  logic [FLIT_W-1:0] rx_flit,
  output logic              rx_ready
);
  // slot bookkeeping
  logic [1:0]    valid_q, pend_q, ev_q;
  logic [CW-1:0] dest_q [SLOTS];
  logic [CW-1:0] gnat_q;
  logic          snd_q, snd_slot_q;
  logic [1:0]    sending;

  // context storage
  logic [XLEN-1:0]     ctx_q [SLOTS][WORDS];
  logic [CTX_BITS-1:0] flat  [SLOTS];

  // interconnect
  logic          miss_valid, miss_slot;
  logic [CW-1:0] miss_home;
  logic          tx_busy, start, sel;
  logic [CW-1:0] hdr_native;
  logic          evict_req, rx_wr, rx_slot, install, inst_slot;
  logic [DIDXW-1:0] rx_fidx;
  logic [FLIT_W-1:0] rx_wflit;
  logic [CW-1:0] inst_native;

  assign sending  = snd_q ? (2'b01 << snd_slot_q) : 2'b00;
  assign slot_run = valid_q & ~pend_q & ~sending;

  assign start      = !tx_busy && !snd_q && (pend_q != 2'b00);
  assign sel        = pend_q[NATIVE_SLOT] ? 1'b0 : 1'b1;
  assign hdr_native = sel ? gnat_q : core_id;

  for (genvar s = 0; s < SLOTS; s++) begin : g_flat
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign flat[s][w*XLEN +: XLEN] = ctx_q[s][w];
    end
  end

  mig_access #(.CW(CW), .AW(AW), .HOME_LSB(HOME_LSB)) u_access (
    .clk, .rst, .core_id,
    .acc_valid, .acc_slot, .acc_write, .acc_addr, .acc_ready,
    .slot_run, .cache_ready,
    .cache_valid, .cache_write, .cache_slot, .cache_addr,
    .miss_valid, .miss_slot, .miss_home
  );

  mig_tx #(.CW(CW), .FLIT_W(FLIT_W), .CTX_BITS(CTX_BITS), .DATA_FLITS(DATA_FLITS)) u_tx (
    .clk, .rst, .start,
    .hdr_dest(dest_q[sel]), .hdr_native, .hdr_evict(ev_q[sel]),
    .ctx(flat[snd_slot_q]),
    .tx_valid, .tx_flit, .tx_ready,
    .busy(tx_busy), .done(tx_done)
  );

  mig_rx #(.CW(CW), .FLIT_W(FLIT_W), .DATA_FLITS(DATA_FLITS), .DIDXW(DIDXW)) u_rx (
    .clk, .rst, .core_id,
    .rx_valid, .rx_flit, .rx_ready,
    .slot_occ(valid_q), .evict_req,
    .wr_en(rx_wr), .wr_slot(rx_slot), .wr_fidx(rx_fidx), .wr_flit(rx_wflit),
    .install, .inst_slot, .inst_native
  );

  // slot state machine: miss requests, eviction demands, departures, arrivals
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q    <= 2'b01;
      pend_q     <= 2'b00;
      ev_q       <= 2'b00;
      dest_q     <= '{default: '0};
      gnat_q     <= '0;
      snd_q      <= 1'b0;
      snd_slot_q <= 1'b0;
    end else begin
      if (miss_valid) begin
        pend_q[miss_slot] <= 1'b1;
        dest_q[miss_slot] <= miss_home;
        ev_q[miss_slot]   <= 1'b0;
      end else if (evict_req && valid_q[GUEST_SLOT] && !pend_q[GUEST_SLOT]
                   && !sending[GUEST_SLOT]) begin
        pend_q[GUEST_SLOT] <= 1'b1;
        dest_q[GUEST_SLOT] <= gnat_q;
        ev_q[GUEST_SLOT]   <= 1'b1;
      end
      if (start) begin
        pend_q[sel] <= 1'b0;
        snd_q       <= 1'b1;
        snd_slot_q  <= sel;
      end else if (tx_done) begin
        snd_q               <= 1'b0;
        valid_q[snd_slot_q] <= 1'b0;
      end
      if (install) begin
        valid_q[inst_slot] <= 1'b1;
        if (inst_slot) gnat_q <= inst_native;
      end
    end
  end

  // context words: arrivals write a whole flit, the pipeline writes one word
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SLOTS; s++)
        for (int w = 0; w < WORDS; w++)
          ctx_q[s][w] <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        for (int w = 0; w < WORDS; w++) begin
          if (rx_wr && int'(rx_slot) == s && int'(rx_fidx) == w / WPF)
            ctx_q[s][w] <= rx_wflit[(w % WPF)*XLEN +: XLEN];
          else if (reg_we && slot_run[s] && int'(reg_slot) == s && int'(reg_idx) == w)
            ctx_q[s][w] <= reg_wdata;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      rd_data <= '0;
    else if (int'(rd_idx) < WORDS) rd_data <= ctx_q[rd_slot][rd_idx];
    else                          rd_data <= '0;
  end
endmodule

// File: rtl/mig_slot_ctrl_chk.sv
module mig_slot_ctrl_chk #(
  parameter int NCORES   = 4,
  parameter int AW       = 32,
  parameter int HOME_LSB = 12,
  parameter int FLIT_W   = 256,
  localparam int CW      = $clog2(NCORES)
) (
  input logic              clk,
  input logic              rst,
  input logic [CW-1:0]     core_id,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic              acc_slot,
  input logic [AW-1:0]     acc_addr,
  input logic              cache_valid,
  input logic              cache_ready,
  input logic [AW-1:0]     cache_addr,
  input logic [1:0]        slot_run,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [FLIT_W-1:0] tx_flit,
  input logic              tx_done
);
  logic is_local;
  assign is_local = (acc_addr[HOME_LSB +: CW] == core_id);

  // R1
  hit_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_ready && is_local |=> cache_valid && cache_addr == $past(acc_addr));

  // R1
  cache_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cache_valid && !cache_ready |=> cache_valid && $stable(cache_addr));

  // R2
  miss_halt_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_ready && !is_local |=> !slot_run[$past(acc_slot)]);

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_flit));

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> !tx_valid);

  // R11
  run_gate_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !slot_run[acc_slot] |-> !acc_ready);
endmodule

bind mig_slot_ctrl mig_slot_ctrl_chk #(
  .NCORES(NCORES), .AW(AW), .HOME_LSB(HOME_LSB), .FLIT_W(FLIT_W)
) u_chk (
  .clk(clk), .rst(rst), .core_id(core_id),
  .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_slot(acc_slot), .acc_addr(acc_addr),
  .cache_valid(cache_valid), .cache_ready(cache_ready), .cache_addr(cache_addr),
  .slot_run(slot_run),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_flit(tx_flit), .tx_done(tx_done)
);

// File: tb/mig_slot_ctrl_bench.sv
`timescale 1ns/1ps
module mig_slot_ctrl_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   core_id = 2'd1;
  logic         acc_valid = 0, acc_slot = 0, acc_write = 0;
  logic [31:0]  acc_addr = '0;
  logic         acc_ready;
  logic         cache_valid, cache_write, cache_slot;
  logic [31:0]  cache_addr;
  logic         cache_ready = 0;
  logic [1:0]   slot_run;
  logic         reg_we = 0, reg_slot = 0;
  logic [5:0]   reg_idx = '0;
  logic [31:0]  reg_wdata = '0;
  logic         rd_slot = 0;
  logic [5:0]   rd_idx = '0;
  logic [31:0]  rd_data;
  logic         tx_valid;
  logic [255:0] tx_flit;
  logic         tx_ready = 0;
  logic         tx_done;
  logic         rx_valid = 0;
  logic [255:0] rx_flit = '0;
  logic         rx_ready;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [255:0] pkt [6];

  always #4 clk = ~clk;

  mig_slot_ctrl u_mig_slot_ctrl (.*);

  task automatic chk(input bit ok, input string what, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [255:0] hdr(input int dest, input int nat, input bit ev);
    logic [255:0] f = '0;
    f[255] = 1'b1; f[1:0] = dest[1:0]; f[3:2] = nat[1:0]; f[4] = ev;
    return f;
  endfunction

  function automatic logic [255:0] dflit(input int k, input logic [31:0] base);
    logic [255:0] f = '0;
    for (int j = 0; j < 8; j++)
      if (8*k + j < 34) f[j*32 +: 32] = base + 32'(8*k + j);
    return f;
  endfunction

  task automatic rd_word(input bit s, input int idx, output logic [31:0] v);
    @(negedge clk); rd_slot = s; rd_idx = 6'(idx);
    @(negedge clk); v = rd_data;
  endtask

  task automatic collect(input string tag);
    int n = 0; int cyc = 0; bit held_v = 0; logic [255:0] held = '0;
    while (n < 6 && cyc < 400) begin
      @(negedge clk); cyc++;
      if (held_v) begin
        chk(tx_valid && tx_flit == held, {tag, " R4 flit held while stalled"}, tx_flit, held);
        held_v = 0;
      end
      tx_ready = (cyc % 3) != 1;
      if (tx_valid && tx_ready) begin pkt[n] = tx_flit; n++; end
      else if (tx_valid) begin held = tx_flit; held_v = 1; end
    end
    chk(n == 6, {tag, " R3 six flits"}, 256'(n), 256'd6);
    @(negedge clk); tx_ready = 0;
    chk(tx_done == 1'b1, {tag, " R4 done pulse"}, 256'(tx_done), 256'd1);
    @(negedge clk);
    chk(tx_done == 1'b0, {tag, " R4 done one cycle"}, 256'(tx_done), 256'd0);
  endtask

  task automatic check_pkt(input string tag, input int dest, input int nat, input bit ev, input logic [31:0] base);
    chk(pkt[0] == hdr(dest, nat, ev), {tag, " R3 header"}, pkt[0], hdr(dest, nat, ev));
    for (int k = 0; k < 5; k++)
      chk(pkt[k+1] == dflit(k, base), {tag, " R3 data flit"}, pkt[k+1], dflit(k, base));
  endtask

  task automatic send_flit(input logic [255:0] f);
    int t = 0;
    rx_valid = 1; rx_flit = f;
    while (!rx_ready && t < 400) begin @(negedge clk); t++; end
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic send_data(input logic [31:0] base);
    for (int k = 0; k < 5; k++) send_flit(dflit(k, base));
  endtask

  task automatic check_slot(input string tag, input bit s, input logic [31:0] base);
    logic [31:0] v;
    for (int i = 0; i < 34; i += 11) begin
      rd_word(s, i, v);
      chk(v == base + 32'(i), {tag, " R6 installed word"}, 256'(v), 256'(base + 32'(i)));
    end
    rd_word(s, 33, v);
    chk(v == base + 32'd33, {tag, " R6 status word"}, 256'(v), 256'(base + 32'd33));
  endtask

  task automatic t_reset;
    logic [31:0] v;
    @(negedge clk);
    chk(slot_run == 2'b01, "R10 slot_run after reset", 256'(slot_run), 256'd1);
    chk(!tx_valid && !cache_valid && rx_ready, "R10 idle handshakes", 256'({tx_valid, cache_valid, rx_ready}), 256'd1);
    rd_word(1'b0, 5, v);
    chk(v == 0, "R10 context zero", 256'(v), 256'd0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    for (int i = 0; i < 34; i++) begin
      @(negedge clk); reg_we = 1; reg_slot = 0; reg_idx = 6'(i); reg_wdata = 32'hA000_0000 + 32'(i);
    end
    @(negedge clk); reg_slot = 1; reg_idx = 6'd3; reg_wdata = 32'hDEAD_BEEF;
    @(negedge clk); reg_we = 0;
    rd_word(1'b0, 32, v);
    chk(v == 32'hA000_0020, "R9 runnable slot written", 256'(v), 256'hA000_0020);
    rd_word(1'b1, 3, v);
    chk(v == 0, "R9 write to empty guest ignored", 256'(v), 256'd0);
  endtask

  task automatic t_hit;
    @(negedge clk); acc_valid = 1; acc_slot = 0; acc_write = 1; acc_addr = 32'h0000_1234; cache_ready = 0;
    chk(acc_ready, "R1 local access accepted", 256'(acc_ready), 256'd1);
    @(negedge clk); acc_valid = 0;
    chk(cache_valid && cache_addr == 32'h0000_1234 && cache_write && !cache_slot,
        "R1 cache request", 256'(cache_addr), 256'h1234);
    @(negedge clk);
    chk(cache_valid && cache_addr == 32'h0000_1234, "R1 cache request held", 256'(cache_valid), 256'd1);
    cache_ready = 1;
    @(negedge clk); cache_ready = 0;
    chk(!cache_valid, "R1 cache request retired", 256'(cache_valid), 256'd0);
  endtask

  task automatic t_miss_native;
    @(negedge clk); acc_valid = 1; acc_slot = 0; acc_write = 0; acc_addr = 32'h0000_2040;
    chk(acc_ready, "R2 remote access accepted", 256'(acc_ready), 256'd1);
    @(negedge clk); acc_valid = 0;
    chk(slot_run[0] == 1'b0, "R2 native slot halted", 256'(slot_run), 256'd0);
    chk(!cache_valid, "R2 no cache request", 256'(cache_valid), 256'd0);
    collect("miss");
    check_pkt("miss", 2, 1, 1'b0, 32'hA000_0000);
    chk(slot_run == 2'b00, "R5 slot empty after send", 256'(slot_run), 256'd0);
    acc_valid = 1; acc_slot = 0; acc_addr = 32'h0000_1000;
    #1;
    chk(!acc_ready, "R11 empty slot access refused", 256'(acc_ready), 256'd0);
    @(negedge clk); acc_valid = 0;
    chk(!cache_valid, "R11 no cache request from empty slot", 256'(cache_valid), 256'd0);
  endtask

  task automatic t_arrive(input int nat, input bit slot, input logic [31:0] base, input logic [1:0] run_exp, input string tag);
    @(negedge clk);
    send_flit(hdr(1, nat, 1'b0));
    send_data(base);
    chk(slot_run == run_exp, {tag, " R6 slot_run after install"}, 256'(slot_run), 256'(run_exp));
    check_slot(tag, slot, base);
  endtask

  task automatic t_evict;
    @(negedge clk);
    send_flit(hdr(1, 2, 1'b0));
    chk(!rx_ready, "R7 rx stalls after header", 256'(rx_ready), 256'd0);
    collect("evict");
    check_pkt("evict R7", 3, 3, 1'b1, 32'h3000_0000);
    send_data(32'h2000_0000);
    chk(slot_run == 2'b11, "R7 new guest running", 256'(slot_run), 256'd3);
    check_slot("evict R7", 1'b1, 32'h2000_0000);
  endtask

  task automatic t_simul;
    @(negedge clk);
    send_flit(hdr(1, 0, 1'b0));
    acc_valid = 1; acc_slot = 0; acc_addr = 32'h0000_3008;
    chk(acc_ready, "R8 native remote access accepted", 256'(acc_ready), 256'd1);
    @(negedge clk); acc_valid = 0;
    collect("both-1");
    check_pkt("both-1 R8 native first", 3, 1, 1'b0, 32'h1000_0000);
    collect("both-2");
    check_pkt("both-2 R8 eviction second", 2, 2, 1'b1, 32'h2000_0000);
    send_data(32'h0E00_0000);
    chk(slot_run == 2'b10, "R8 guest from core 0 running", 256'(slot_run), 256'd2);
    check_slot("both R6", 1'b1, 32'h0E00_0000);
  endtask

  initial begin
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_regs();
    t_hit();
    t_miss_native();
    t_arrive(1, 1'b0, 32'h1000_0000, 2'b01, "native");
    t_arrive(3, 1'b1, 32'h3000_0000, 2'b11, "guest");
    t_evict();
    t_simul();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule